// File: doc/BRIEF.md
# Shift-Based Piecewise-Linear Activation Unit

This unit sits at the end of a quantized neural-network datapath. It turns a signed 16-bit accumulator value into a low-precision activation. The transfer curve is split into up to eight linear pieces. A small set of magnitude comparators against programmable breakpoints picks the piece that applies. Each piece has a power-of-two slope, so the input is scaled only by a chain of one-bit arithmetic right-shift stages, with an optional negation. A signed intercept is then added. The sum saturates to a signed output width of 2, 4 or 8 bits, chosen at run time.

Software loads the breakpoints, the per-piece shift and sign, the intercepts and the output width through an address/data/write-enable port. Every register can be read back. With a suitable program the same hardware approximates smooth functions such as SiLU, or acts as a plain clipping quantizer. After reset it acts as identity followed by 8-bit saturation. The stream side takes one value per cycle and returns each result exactly three cycles later, with the valid flag carried along.

Top module: `pwl_act_unit`

## Requirements
- R1: After reset all breakpoints read 32767 and all segment controls, all intercepts and the output data read 0. The width code reads 2, so the unit computes saturate8(x).
- R2: The segment index equals the number of breakpoints b[i] with x >= b[i] (signed compare), so an input equal to a breakpoint falls in the upper segment. Breakpoints are assumed ascending.
- R3: The slope term is x arithmetically shifted right by the segment's shift count (0..15, rounding toward minus infinity). It is negated when the segment's sign bit is set. A segment control word holds the sign in bit 4 and the shift count in bits 3:0.
- R4: The result before saturation is intercept + slope term, computed wide enough that it never wraps, even at full-scale inputs and intercepts.
- R5: The result saturates to the signed range of the selected width. Width code 0 gives 2 bits [-2,1], code 1 gives 4 bits [-8,7], codes 2 and 3 give 8 bits [-128,127]. out_data is sign-extended to 8 bits.
- R6: out_valid rises exactly three clock cycles after in_valid is sampled. Back-to-back inputs give back-to-back results, in order, one per cycle.
- R7: Register map: breakpoints at addresses 0..6, segment controls at 8..15, intercepts at 16..23, width code (bits 1:0) at 24. cfg_rdata returns the addressed register zero-extended, and 0 for unmapped addresses.
- R8: A write is ignored if in_valid is high in that cycle or an input still sits in either of the first two pipeline stages. Results in flight keep the old configuration. A write in an idle cycle takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 16 | Signed input value |
| out_valid | output | 1 | Result valid, three cycles after input |
| out_data | output | 8 | Saturated signed result, sign-extended |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Read-back of the addressed register |

## Verification
A configuration write and a stream input can land in the same cycle. A write can also arrive while an earlier sample is still in the compare or shift stage. The bench provokes both cases. It raises cfg_we together with in_valid, then retries on the next two cycles while that sample moves down the pipeline. It judges the outcome by reading back the targeted intercept, which must be unchanged. It also checks that the sample's result, popped from the scoreboard, was computed with the old intercept. A final write in an idle cycle must then show up in the read-back.

// File: rtl/pwl_act_pkg.sv
package pwl_act_pkg;

  typedef enum logic [1:0] {
    OW_2B   = 2'd0,
    OW_4B   = 2'd1,
    OW_8B   = 2'd2,
    OW_8B_X = 2'd3
  } ow_sel_e;

  localparam logic [1:0] OW_RESET = 2'd2;

  // Number of signed bits kept for a width code.
  function automatic int ow_bits(input logic [1:0] code);
    case (ow_sel_e'(code))
      OW_2B:   return 2;
      OW_4B:   return 4;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/pwl_act_cfg.sv
module pwl_act_cfg #(
  parameter int DW   = 16,
  parameter int NSEG = 8,
  parameter int SHW  = 4,
  parameter int AW   = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  input  logic                          busy,
  output logic [DW-1:0]                 rdata,
  output logic [NSEG-2:0][DW-1:0]       bp_o,
  output logic [NSEG-1:0][SHW:0]        sc_o,
  output logic [NSEG-1:0][DW-1:0]       ic_o,
  output logic [1:0]                    wsel_o,
  output logic                          commit_o
);
  import pwl_act_pkg::*;

  localparam int NBP     = NSEG - 1;
  localparam int SC_BASE = NSEG;
  localparam int IC_BASE = 2 * NSEG;
  localparam int WS_ADDR = 3 * NSEG;
  localparam logic [DW-1:0] BP_MAX = {1'b0, {(DW-1){1'b1}}};

  logic [NSEG-2:0][DW-1:0] bp_q;
  logic [NSEG-1:0][SHW:0]  sc_q;
  logic [NSEG-1:0][DW-1:0] ic_q;
  logic [1:0]              wsel_q;

  assign commit_o = we & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBP; i++)  bp_q[i] <= BP_MAX;
      for (int i = 0; i < NSEG; i++) sc_q[i] <= '0;
      for (int i = 0; i < NSEG; i++) ic_q[i] <= '0;
      wsel_q <= OW_RESET;
    end else if (commit_o) begin
      for (int i = 0; i < NBP; i++)
        if (addr == AW'(i)) bp_q[i] <= wdata;
      for (int i = 0; i < NSEG; i++) begin
        if (addr == AW'(SC_BASE + i)) sc_q[i] <= wdata[SHW:0];
        if (addr == AW'(IC_BASE + i)) ic_q[i] <= wdata;
      end
      if (addr == AW'(WS_ADDR)) wsel_q <= wdata[1:0];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NBP; i++)
      if (addr == AW'(i)) rdata = bp_q[i];
    for (int i = 0; i < NSEG; i++) begin
      if (addr == AW'(SC_BASE + i)) rdata = DW'(sc_q[i]);
      if (addr == AW'(IC_BASE + i)) rdata = ic_q[i];
    end
    if (addr == AW'(WS_ADDR)) rdata = DW'(wsel_q);
  end

  assign bp_o   = bp_q;
  assign sc_o   = sc_q;
  assign ic_o   = ic_q;
  assign wsel_o = wsel_q;

endmodule

// File: rtl/pwl_seg_select.sv
module pwl_seg_select #(
  parameter int DW   = 16,
  parameter int NSEG = 8,
  parameter int SW   = 3
) (
  input  logic [DW-1:0]           x,
  input  logic [NSEG-2:0][DW-1:0] bp,
  output logic [NSEG-2:0]         ge_o,
  output logic [SW-1:0]           seg_o
);
  localparam int NBP = NSEG - 1;

  // One comparator per breakpoint; equality selects the upper segment.
  for (genvar g = 0; g < NBP; g++) begin : g_cmp
    assign ge_o[g] = $signed(x) >= $signed(bp[g]);
  end

  always_comb begin
    seg_o = '0;
    for (int i = 0; i < NBP; i++) seg_o = seg_o + SW'(ge_o[i]);
  end

endmodule

// File: rtl/pwl_shift_cascade.sv
module pwl_shift_cascade #(
  parameter int DW  = 16,
  parameter int SHW = 4
) (
  input  logic [DW-1:0]        x,
  input  logic [SHW-1:0]       sh,
  input  logic                 neg,
  output logic signed [DW:0]   term_o
);
  localparam int NST = (1 << SHW) - 1;

  logic signed [DW-1:0] st [NST+1];
  logic signed [DW:0]   ext;

  assign st[0] = $signed(x);

  // Stage g applies one arithmetic shift when the count exceeds g.
  for (genvar g = 0; g < NST; g++) begin : g_stage
    assign st[g+1] = (sh > SHW'(g)) ? (st[g] >>> 1) : st[g];
  end

  assign ext    = $signed({st[NST][DW-1], st[NST]});
  assign term_o = neg ? -ext : ext;

endmodule

// File: rtl/pwl_act_unit.sv
module pwl_act_unit #(
  parameter int DW   = 16,
  parameter int NSEG = 8,
  parameter int SHW  = 4,
  parameter int OUTW = 8,
  parameter int AW   = $clog2(3 * NSEG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  output logic [OUTW-1:0]  out_data,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata
);
  import pwl_act_pkg::*;

  localparam int SW   = $clog2(NSEG);
  localparam int SUMW = DW + 2;

  function automatic logic [OUTW-1:0] sat_q(input logic signed [SUMW-1:0] s,
                                            input logic [1:0] code);
    int b;
    logic signed [SUMW-1:0] hi, lo, r;
    b  = ow_bits(code);
    hi = $signed((SUMW'(1) << (b - 1)) - SUMW'(1));
    lo = -hi - $signed(SUMW'(1));
    if (s > hi)      r = hi;
    else if (s < lo) r = lo;
    else             r = s;
    return r[OUTW-1:0];
  endfunction

  // configuration
  logic [NSEG-2:0][DW-1:0] bp;
  logic [NSEG-1:0][SHW:0]  sc;
  logic [NSEG-1:0][DW-1:0] ic;
  logic [1:0]              wsel_q;
  logic                    cfg_commit;
  logic                    busy;

  // pipeline state
  logic                    s1_v, s2_v;
  logic [DW-1:0]           s1_x;
  logic [SW-1:0]           s1_seg;
  logic signed [DW:0]      s2_term;
  logic signed [DW-1:0]    s2_ic;

  // named internal events
  logic [NSEG-2:0]         seg_ge;
  logic [SW-1:0]           seg_idx;
  logic signed [DW:0]      term_c;
  logic [SHW:0]            ctl_c;
  logic signed [SUMW-1:0]  sum_c;

  assign busy = in_valid | s1_v | s2_v;

  pwl_act_cfg #(.DW(DW), .NSEG(NSEG), .SHW(SHW), .AW(AW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .busy     (busy),
    .rdata    (cfg_rdata),
    .bp_o     (bp),
    .sc_o     (sc),
    .ic_o     (ic),
    .wsel_o   (wsel_q),
    .commit_o (cfg_commit)
  );

  pwl_seg_select #(.DW(DW), .NSEG(NSEG), .SW(SW)) u_sel (
    .x     (in_data),
    .bp    (bp),
    .ge_o  (seg_ge),
    .seg_o (seg_idx)
  );

  assign ctl_c = sc[s1_seg];

  pwl_shift_cascade #(.DW(DW), .SHW(SHW)) u_shift (
    .x      (s1_x),
    .sh     (ctl_c[SHW-1:0]),
    .neg    (ctl_c[SHW]),
    .term_o (term_c)
  );

  assign sum_c = $signed({{2{s2_ic[DW-1]}}, s2_ic}) + $signed({s2_term[DW], s2_term});

  // stage 1: compare
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_x   <= '0;
      s1_seg <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_x   <= in_data;
        s1_seg <= seg_idx;
      end
    end
  end

  // stage 2: shift
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v    <= 1'b0;
      s2_term <= '0;
      s2_ic   <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_term <= term_c;
        s2_ic   <= $signed(ic[s1_seg]);
      end
    end
  end

  // stage 3: add and saturate
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s2_v;
      if (s2_v) out_data <= sat_q(sum_c, wsel_q);
    end
  end

endmodule

// File: rtl/pwl_act_checker.sv
module pwl_act_checker #(
  parameter int DW   = 16,
  parameter int OUTW = 8,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            out_valid,
  input logic [OUTW-1:0] out_data,
  input logic            cfg_we,
  input logic [AW-1:0]   cfg_addr,
  input logic [DW-1:0]   cfg_rdata,
  input logic [1:0]      wsel
);
  import pwl_act_pkg::*;

  logic [1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n)             since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  // Upper bits from the sign position of the selected width must all agree.
  function automatic logic fits(input logic [OUTW-1:0] d, input logic [1:0] code);
    int b;
    logic ok;
    b  = ow_bits(code);
    ok = 1'b1;
    for (int i = 0; i < OUTW; i++)
      if (i >= b - 1 && d[i] != d[OUTW-1]) ok = 1'b0;
    return ok;
  endfunction

  // R1: nothing valid leaves the unit before a sample can cross the pipeline
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (since != 2'd3) |-> !out_valid);

  // R6: fixed three-cycle latency
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R6: valid results carry known data
  a_r6_known: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_data));

  // R5: results fit the selected signed width
  a_r5_fits_width: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> fits(out_data, wsel));

  // R8: a write colliding with an input leaves the register unchanged
  a_r8_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    ((since != 2'd0) && $past(cfg_we && in_valid) && (cfg_addr == $past(cfg_addr)))
      |-> (cfg_rdata == $past(cfg_rdata)));

endmodule

bind pwl_act_unit pwl_act_checker #(.DW(DW), .OUTW(OUTW), .AW(AW)) u_pwl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .wsel      (wsel_q)
);

// File: tb/pwl_act_unit_bench.sv
module pwl_act_unit_bench;

  localparam int NBP = 7;
  localparam int NSG = 8;
  localparam int SCB = 8;
  localparam int ICB = 16;
  localparam int WSA = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;

  pwl_act_unit u_pwl_act_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  always #10 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // shadow configuration
  int sbp [NBP];
  int ssh [NSG];
  int sneg[NSG];
  int sic [NSG];
  int swsel;

  // scoreboard
  int    exp_q[$];
  int    cyc_q[$];
  string tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int x);
    int seg, t, s, b, hi;
    seg = 0;
    for (int i = NBP - 1; i >= 0; i--)
      if (x >= sbp[i]) begin seg = i + 1; break; end
    t = x >>> ssh[seg];
    if (sneg[seg] != 0) t = -t;
    s  = sic[seg] + t;
    b  = (swsel == 0) ? 2 : (swsel == 1) ? 4 : 8;
    hi = (1 << (b - 1)) - 1;
    if (s > hi) s = hi;
    else if (s < -hi - 1) s = -hi - 1;
    return s;
  endfunction

  function automatic int sx16(input int v);
    return (v & 32'h8000) != 0 ? (v | 32'hFFFF0000) : (v & 32'hFFFF);
  endfunction

  task automatic cfg_write(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < NBP) sbp[a] = sx16(d);
    else if (a >= SCB && a < SCB + NSG) begin
      ssh[a - SCB] = d & 15; sneg[a - SCB] = (d >> 4) & 1;
    end else if (a >= ICB && a < ICB + NSG) sic[a - ICB] = sx16(d);
    else if (a == WSA) swsel = d & 3;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk);
    cfg_addr = 5'(a);
    #2;
    chk(int'(cfg_rdata) == (exp & 32'hFFFF), tag, int'(cfg_rdata), exp & 32'hFFFF);
  endtask

  task automatic send(input int x, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'(x);
    exp_q.push_back(model(x)); cyc_q.push_back(cyc); tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected result", 1, 0);
      else begin
        int e, c; string t;
        e = exp_q.pop_front(); c = cyc_q.pop_front(); t = tag_q.pop_front();
        chk(int'($signed(out_data)) == e, t, int'($signed(out_data)), e);
        chk(cyc - c == 3, "R6 latency", cyc - c, 3);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NBP; i++) sbp[i] = 32767;
    for (int i = 0; i < NSG; i++) begin ssh[i] = 0; sneg[i] = 0; sic[i] = 0; end
    swsel = 2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(out_data == 8'd0, "R1 out_data after reset", int'(out_data), 0);
    rd_chk(0, 32767, "R1 bp0 reset");
    rd_chk(6, 32767, "R1 bp6 reset");
    rd_chk(SCB + 3, 0, "R1 segctl reset");
    rd_chk(ICB + 7, 0, "R1 intercept reset");
    rd_chk(WSA, 2, "R1 width reset");

    // R1/R5/R6 identity with 8-bit saturation, back to back
    send(100, "R1 identity 100");
    send(-300, "R5 identity clip low");
    send(1000, "R5 identity clip high");
    send(-128, "R5 edge -128");
    send(127, "R5 edge 127");
    send(32767, "R1 max input");
    idle(5);

    // program the curve
    cfg_write(0, -1000); cfg_write(1, -100); cfg_write(2, 0); cfg_write(3, 100);
    cfg_write(4, 500);   cfg_write(5, 2000); cfg_write(6, 8000);
    cfg_write(SCB + 0, 16 + 4); cfg_write(SCB + 1, 3); cfg_write(SCB + 2, 0);
    cfg_write(SCB + 3, 16 + 1); cfg_write(SCB + 4, 2); cfg_write(SCB + 5, 5);
    cfg_write(SCB + 6, 16 + 7); cfg_write(SCB + 7, 15);
    cfg_write(ICB + 0, -60); cfg_write(ICB + 3, 5); cfg_write(ICB + 4, -20);
    cfg_write(ICB + 5, 30);  cfg_write(ICB + 6, 100); cfg_write(ICB + 7, -3);

    // R7 read-back
    rd_chk(1, -100, "R7 bp readback");
    rd_chk(SCB + 6, 23, "R7 segctl readback");
    rd_chk(ICB + 0, -60, "R7 intercept readback");
    rd_chk(7, 0, "R7 unmapped addr 7");
    rd_chk(30, 0, "R7 unmapped addr 30");

    // R2 boundaries: each breakpoint and one below
    send(-1001, "R2 below bp0"); send(-1000, "R2 at bp0");
    send(-101, "R2 below bp1");  send(-100, "R2 at bp1");
    send(-1, "R2 below bp2");    send(0, "R2 at bp2");
    send(99, "R2 below bp3");    send(100, "R2 at bp3");
    send(499, "R2 below bp4");   send(500, "R2 at bp4");
    send(1999, "R2 below bp5");  send(2000, "R2 at bp5");
    send(7999, "R2 below bp6");  send(8000, "R2 at bp6");
    // R3 floor rounding on negative inputs and negated slopes
    send(-1009, "R3 floor shift4 neg");
    send(-999, "R3 floor shift3");
    send(3, "R3 shift1 negated");
    send(-32768, "R3 full-scale negative");
    idle(5);

    // R4 no wrap at full scale
    cfg_write(SCB + 7, 0); cfg_write(ICB + 7, 32767);
    cfg_write(SCB + 0, 16); cfg_write(ICB + 0, 32767);
    send(32767, "R4 wide sum high");
    send(-32768, "R4 wide sum negated");
    idle(5);

    // R5 width codes
    cfg_write(SCB + 2, 0); cfg_write(ICB + 2, 0);
    cfg_write(WSA, 0);
    send(-50, "R5 2-bit clip low"); send(-2, "R5 2-bit min"); send(-1, "R5 2-bit in range");
    send(7000, "R5 2-bit clip high");
    idle(5);
    cfg_write(WSA, 1);
    send(-50, "R5 4-bit clip low"); send(-8, "R5 4-bit min"); send(7000, "R5 4-bit clip high");
    idle(5);
    cfg_write(WSA, 3);
    send(-50, "R5 code3 8-bit"); send(-100, "R5 code3 at bp1");
    idle(5);
    rd_chk(WSA, 3, "R7 width readback");

    // R8 collisions: write with in_valid, then while stage 1 and 2 hold it
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'(-50);
    exp_q.push_back(model(-50)); cyc_q.push_back(cyc); tag_q.push_back("R8 old intercept used");
    cfg_we = 1'b1; cfg_addr = 5'(ICB + 2); cfg_wdata = 16'd40;
    @(negedge clk);
    in_valid = 1'b0;
    #2 chk(int'(cfg_rdata) == 0, "R8 write with in_valid ignored", int'(cfg_rdata), 0);
    @(negedge clk);
    #2 chk(int'(cfg_rdata) == 0, "R8 write during stage1 ignored", int'(cfg_rdata), 0);
    @(negedge clk);
    cfg_we = 1'b0;
    #2 chk(int'(cfg_rdata) == 0, "R8 write during stage2 ignored", int'(cfg_rdata), 0);
    idle(4);
    cfg_write(ICB + 2, 40);
    rd_chk(ICB + 2, 40, "R8 idle write accepted");
    send(-50, "R8 new intercept used");
    idle(5);

    chk(exp_q.size() == 0, "R6 all results returned", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule